// File: doc/BRIEF.md
# Programmable-Length Bidirectional Shift Register

This block holds a 64-bit register of which only the lowest |N| bits form the active shift window. N arrives as one signed operand: its magnitude sets the window length and its sign sets the direction. Each rising edge of the step input moves the window one place and shifts a serial bit into it. The bit that falls out of the window is kept in an overflow flag. A zero flag reports whether the window is empty after the move.

A parallel load port sets all 64 bits at once, for example to seed a step sequencer. Bits above the window keep their values through any number of shifts, so one wide register can hold a short sequencer together with unrelated static bits. An N of zero is refused. The error output reports it, and the stored state is left as it was.

Top module: `prog_shift_reg`

## Requirements
- R1: A synchronous reset, active high, clears the register, the overflow flag, the zero flag and the error output to 0.
- R2: When load_en is high at a clock edge, all 64 bits take load_data, even if a shift is also due at that edge. A load leaves the overflow, zero and error outputs unchanged.
- R3: A shift happens only at the first clock edge at which step_in is sampled high after being sampled low. Holding step_in high gives no further shifts.
- R4: len_sel is a 7-bit two's-complement value from -64 to 63. A positive value selects a forward shift: din enters bit 0 and every other window bit moves up one position.
- R5: A negative len_sel selects a reverse shift: din enters bit |len_sel|-1 and every other window bit moves down one position.
- R6: After a legal shift, ovf holds the bit that left the window: the old bit |len_sel|-1 for a forward shift, the old bit 0 for a reverse shift.
- R7: After a legal shift, zero is 1 exactly when bits 0 to |len_sel|-1 of the new register value are all 0.
- R8: A shift never modifies bits at positions |len_sel| and above.
- R9: A shift request with len_sel equal to 0 sets err to 1 and leaves the register, ovf and zero unchanged. The next legal shift clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_in | input | 1 | Shift request; acts on its rising edge |
| din | input | 1 | Serial bit shifted into the window |
| len_sel | input | 7 | Signed window length and direction |
| load_en | input | 1 | Parallel load strobe |
| load_data | input | 64 | Parallel load value |
| q | output | 64 | Register contents |
| ovf | output | 1 | Bit shifted out by the last legal shift |
| zero | output | 1 | Window was all zero after the last legal shift |
| err | output | 1 | Last shift request had an illegal length |

## Verification
The case that is hardest to reach from the ports is a full-width or nearly full-width window next to untouched upper bits. Reaching it needs the whole register seeded with a known pattern that has marker bits at both ends. The stimulus therefore uses the parallel load to place such patterns, then requests a shift of length -64 and one of length 63. The first shows the last bit leaving through the overflow flag; the second shows that bit 63 stays put. A second hard case is a load and a rising step edge at the same clock. The bench sets up that collision directly and keeps step_in high afterwards, so that no late shift can hide a priority error.

// File: rtl/prog_shift_reg.sv
module prog_shift_reg #(
  parameter int WIDTH = 64,
  parameter int NW    = $clog2(WIDTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_in,
  input  logic             din,
  input  logic [NW-1:0]    len_sel,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] q,
  output logic             ovf,
  output logic             zero,
  output logic             err
);
  localparam int AW = $clog2(WIDTH);

  logic step_d;
  wire  fire = step_in & ~step_d;

  wire          neg   = len_sel[NW-1];
  wire [NW-1:0] mag   = neg ? (~len_sel + 1'b1) : len_sel;
  wire          legal = (mag != '0) && (mag <= NW'(WIDTH));
  wire [NW-1:0] hi    = mag - 1'b1;

  logic [WIDTH-1:0] win, nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic lo, up;
    if (i == 0) begin : g_lo0
      assign lo = din;
    end else begin : g_lon
      assign lo = q[i-1];
    end
    if (i == WIDTH-1) begin : g_uptop
      assign up = din;
    end else begin : g_upn
      assign up = q[i+1];
    end
    assign win[i] = NW'(i) < mag;
    assign nxt[i] = !win[i] ? q[i] :
                    neg     ? ((NW'(i) == hi) ? din : up) : lo;
  end

  wire ovf_n  = neg ? q[0] : q[hi[AW-1:0]];
  wire zero_n = (nxt & win) == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_d <= 1'b0;
      q      <= '0;
      ovf    <= 1'b0;
      zero   <= 1'b0;
      err    <= 1'b0;
    end else begin
      step_d <= step_in;
      if (load_en) begin
        q <= load_data;
      end else if (fire) begin
        if (legal) begin
          q    <= nxt;
          ovf  <= ovf_n;
          zero <= zero_n;
          err  <= 1'b0;
        end else begin
          err  <= 1'b1;
        end
      end
    end
  end
endmodule

module prog_shift_reg_chk #(
  parameter int WIDTH = 64,
  parameter int NW    = $clog2(WIDTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             step_in,
  input logic             din,
  input logic [NW-1:0]    len_sel,
  input logic             load_en,
  input logic [WIDTH-1:0] load_data,
  input logic [WIDTH-1:0] q,
  input logic             ovf,
  input logic             zero,
  input logic             err
);
  logic prev_step;
  always_ff @(posedge clk) prev_step <= rst ? 1'b0 : step_in;

  int cmag;
  logic [WIDTH-1:0] cmask;
  always_comb begin
    cmag = int'($signed(len_sel));
    if (cmag < 0) cmag = -cmag;
    for (int k = 0; k < WIDTH; k++) cmask[k] = (k < cmag);
  end

  wire req   = step_in && !prev_step && !load_en;
  wire okreq = req && (len_sel != '0);

  p_reset_r1: assert property (@(posedge clk) rst |=> (q == '0) && !ovf && !zero && !err);
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (q == $past(load_data)) && $stable(ovf) && $stable(zero) && $stable(err));
  p_no_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !(step_in && !prev_step)) |=> $stable(q) && $stable(ovf) && $stable(err));
  p_fwd_in_r4: assert property (@(posedge clk) disable iff (rst)
    (okreq && !len_sel[NW-1]) |=> q[0] == $past(din));
  p_rev_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    (okreq && len_sel[NW-1]) |=> ovf == $past(q[0]));
  p_zero_r7: assert property (@(posedge clk) disable iff (rst)
    okreq |=> zero == ((q & $past(cmask)) == '0));
  p_top_r8: assert property (@(posedge clk) disable iff (rst)
    (req && cmag < WIDTH) |=> q[WIDTH-1] == $past(q[WIDTH-1]));
  p_bad_len_r9: assert property (@(posedge clk) disable iff (rst)
    (req && len_sel == '0) |=> err && $stable(q) && $stable(ovf) && $stable(zero));
endmodule

bind prog_shift_reg prog_shift_reg_chk #(.WIDTH(WIDTH), .NW(NW)) u_chk (.*);

// File: tb/prog_shift_reg_tb.sv
`timescale 1ns/1ps
module prog_shift_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_in = 1'b0;
  logic        din = 1'b0;
  logic [6:0]  len_sel = 7'd1;
  logic        load_en = 1'b0;
  logic [63:0] load_data = '0;
  logic [63:0] q;
  logic        ovf, zero, err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  prog_shift_reg u_dut (.*);

  localparam logic [63:0] SEED = 64'hF0F0_F0F0_F0F0_F005;

  // {len, din, expected low byte, expected ovf, expected zero}
  localparam logic [17:0] VEC [0:12] = '{
    {7'sd4,  1'b1, 8'h0B, 1'b0, 1'b0},
    {7'sd4,  1'b0, 8'h06, 1'b1, 1'b0},
    {-7'sd4, 1'b1, 8'h0B, 1'b0, 1'b0},
    {-7'sd4, 1'b0, 8'h05, 1'b1, 1'b0},
    {7'sd2,  1'b0, 8'h06, 1'b0, 1'b0},
    {7'sd1,  1'b0, 8'h06, 1'b0, 1'b1},
    {-7'sd1, 1'b1, 8'h07, 1'b0, 1'b0},
    {7'sd8,  1'b0, 8'h0E, 1'b0, 1'b0},
    {-7'sd8, 1'b1, 8'h87, 1'b0, 1'b0},
    {-7'sd8, 1'b0, 8'h43, 1'b1, 1'b0},
    {7'sd3,  1'b0, 8'h46, 1'b0, 1'b0},
    {7'sd3,  1'b0, 8'h44, 1'b1, 1'b0},
    {7'sd3,  1'b0, 8'h40, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [63:0] v);
    @(negedge clk); load_en = 1'b1; load_data = v;
    @(negedge clk); load_en = 1'b0;
  endtask

  task automatic shift(input logic [6:0] n, input logic d);
    @(negedge clk); len_sel = n; din = d; step_in = 1'b1;
    @(negedge clk); step_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] sq;
    logic so, sz;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset q", q, 64'h0);
    chk("R1 reset flags", {61'h0, ovf, zero, err}, 64'h0);

    load(SEED);
    chk("R2 load", q, SEED);
    for (int i = 0; i <= 12; i++) begin
      shift(VEC[i][17:11], VEC[i][10]);
      chk($sformatf("R4/R5 vec %0d q", i), q, {SEED[63:8], VEC[i][9:2]});
      chk($sformatf("R6 vec %0d ovf", i), {63'h0, ovf}, {63'h0, VEC[i][1]});
      chk($sformatf("R7 vec %0d zero", i), {63'h0, zero}, {63'h0, VEC[i][0]});
    end
    chk("R8 upper bits kept", {8'h0, q[63:8]}, {8'h0, SEED[63:8]});

    // R3: held step gives one shift
    load(SEED);
    @(negedge clk); len_sel = 7'sd4; din = 1'b1; step_in = 1'b1;
    repeat (5) @(negedge clk);
    step_in = 1'b0;
    @(negedge clk);
    chk("R3 single shift while held", q, {SEED[63:8], 8'h0B});

    // R9: zero length refused
    sq = q; so = ovf; sz = zero;
    shift(7'd0, 1'b1);
    chk("R9 err set", {63'h0, err}, 64'h1);
    chk("R9 q held", q, sq);
    chk("R9 flags held", {62'h0, ovf, zero}, {62'h0, so, sz});
    shift(7'sd4, 1'b0);
    chk("R9 err cleared", {63'h0, err}, 64'h0);

    // R2: load beats a simultaneous shift, flags unchanged
    so = ovf; sz = zero;
    @(negedge clk); load_en = 1'b1; load_data = 64'h1234_5678_9ABC_DEF0;
    len_sel = 7'sd4; din = 1'b1; step_in = 1'b1;
    @(negedge clk); load_en = 1'b0;
    @(negedge clk); step_in = 1'b0;
    @(negedge clk);
    chk("R2 load priority", q, 64'h1234_5678_9ABC_DEF0);
    chk("R2 flags unchanged", {62'h0, ovf, zero}, {62'h0, so, sz});

    // R5/R6/R7: full-width reverse
    load(64'h1);
    shift(-7'sd64, 1'b0);
    chk("R5 full reverse q", q, 64'h0);
    chk("R6 full reverse ovf", {63'h0, ovf}, 64'h1);
    chk("R7 full reverse zero", {63'h0, zero}, 64'h1);

    // R8/R4: window of 63 leaves bit 63
    load(64'h8000_0000_0000_0001);
    shift(7'sd63, 1'b1);
    chk("R8 top bit kept, R4 shift", q, 64'h8000_0000_0000_0003);
    chk("R6 window 63 ovf", {63'h0, ovf}, 64'h0);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 mid reset", {q[60:0], ovf, zero, err}, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule